// File: doc/BRIEF.md
# Precision Gamma Lookup Table with Auto-Incrementing Loader

This block is the colour lookup stage of a display pipe. It holds a table of entries, each packing a 10-bit red, green and blue value. A host loads the table by writing an index register and then streaming words into a data register. The loader pointer can step forward by itself after every data access, so a whole table goes in as one burst of data writes. A split flag divides the table into two regions. The lower region holds the degamma curve. The upper region holds the gamma curve and starts at an offset equal to the degamma table size. Three 16-bit ceiling registers, one per channel, give the result for pixel inputs beyond the end of the active table.

Each pixel channel indexes its own copy of the table. The selected 10-bit component is widened to 16 bits by repeating its upper bits, so that full scale maps to 0xFFFF. Any channel input past the active range returns that channel's ceiling register instead. The table region that pixels see depends on the split flag. Reads of the data register return the entry under the pointer and step the pointer the same way writes do. This lets a loaded table be read back.

Top module: `gamma_lut`

## Requirements
- R1: After a synchronous reset the pointer is 0, auto-step and split flags are clear, all three ceiling registers read 0xFFFF, and cfg_rvalid and px_out_valid are low.
- R2: A write to the index register (cfg_sel=0) with bit 31 clear loads the pointer from bits 15:0, clamped to DEPTH. It clears auto-step and loads the split flag from bit 30. An index read returns auto-step in bit 31, split in bit 30 and the pointer in the low bits.
- R3: A data write (cfg_sel=1) stores red from bits 29:20, green from bits 19:10 and blue from bits 9:0 at the pointer. With auto-step set, the pointer then advances by one.
- R4: With auto-step clear, data writes leave the pointer unchanged, so the next write overwrites the same entry.
- R5: An index write with bit 31 set sets auto-step and loads split from bit 30, but leaves the pointer unchanged whatever bits 15:0 hold.
- R6: The pointer never passes DEPTH. At DEPTH, data writes are discarded and data reads return 0, and the pointer stays put.
- R7: A data read raises cfg_rvalid one cycle later with the entry at the pointer, packed as in R3 with bits 31:30 zero. The read advances the pointer only when auto-step is set.
- R8: A pixel presented with px_valid appears two cycles later with px_out_valid. Each channel looks up its own input and outputs {c, c[9:4]} for the 10-bit component c.
- R9: With split set, pixel input v reads entry DEG_SIZE+v, and the active range is DEPTH-DEG_SIZE. With split clear, v reads entry v and the range is DEPTH.
- R10: A channel input at or above the active range outputs that channel's ceiling register instead of a table entry.
- R11: Ceiling registers (cfg_sel 2, 3, 4 for red, green, blue) take bits 15:0 of a write and read back zero-extended. A write to one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Host write strobe |
| cfg_rd | input | 1 | Host read strobe (ignored when cfg_wr is high) |
| cfg_sel | input | 3 | Register select: 0 index, 1 data, 2/3/4 red/green/blue ceiling |
| cfg_wdata | input | 32 | Host write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| cfg_rdata | output | 32 | Read data |
| px_valid | input | 1 | Pixel input valid |
| px_r | input | PX_W | Red input index |
| px_g | input | PX_W | Green input index |
| px_b | input | PX_W | Blue input index |
| px_out_valid | output | 1 | Pixel output valid |
| px_out_r | output | MAX_W | Red output |
| px_out_g | output | MAX_W | Green output |
| px_out_b | output | MAX_W | Blue output |

## Verification
The hardest state to reach is the pointer sitting at DEPTH with auto-step on. Writes there must vanish and reads must return zero without disturbing the last real entry. The stimulus parks the pointer on the final entry with a plain index write, and only then turns on auto-step with a write whose index bits would otherwise move it. One data write then pushes the pointer onto the end. Later pixel lookups at the top of both the split and unsplit ranges read that last entry back, one step below the ceiling-register boundary.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum logic [2:0] {
    SEL_INDEX = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_MAX_R = 3'd2,
    SEL_MAX_G = 3'd3,
    SEL_MAX_B = 3'd4
  } reg_sel_e;

  localparam int AUTO_BIT    = 31;
  localparam int SPLIT_BIT   = 30;
  localparam int IDX_FIELD_W = 16;
  localparam int NUM_CH      = 3;
endpackage

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_re,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // host port: write or read at the loader pointer
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_re) a_q <= mem[a_addr];
  end

  // pixel port: read only
  always_ff @(posedge clk) begin
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9,
  parameter int PTR_W  = 10,
  parameter int MAX_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr,
  input  logic                          cfg_rd,
  input  logic [2:0]                    cfg_sel,
  input  logic                          ctl_auto,
  input  logic                          ctl_split,
  input  logic [IDX_FIELD_W-1:0]        ctl_field,
  output logic                          mem_we,
  output logic                          mem_re,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [PTR_W-1:0]              ptr_o,
  output logic                          auto_o,
  output logic                          split_o,
  output logic [NUM_CH-1:0][MAX_W-1:0]  max_o,
  output logic                          rvalid_o,
  output logic                          rsel_data_o,
  output logic                          rvoid_o,
  output logic [31:0]                   rreg_o
);
  logic            wr_idx, wr_dat, rd_any, rd_dat, in_tab;
  logic [PTR_W-1:0] idx_load;
  logic [31:0]     idx_view;

  assign wr_idx   = cfg_wr && (cfg_sel == SEL_INDEX);
  assign wr_dat   = cfg_wr && (cfg_sel == SEL_DATA);
  assign rd_any   = cfg_rd && !cfg_wr;
  assign rd_dat   = rd_any && (cfg_sel == SEL_DATA);
  assign in_tab   = ptr_o < PTR_W'(DEPTH);
  assign mem_we   = wr_dat && in_tab;
  assign mem_re   = rd_dat && in_tab;
  assign mem_addr = ptr_o[ADDR_W-1:0];
  assign idx_load = (32'(ctl_field) >= DEPTH) ? PTR_W'(DEPTH) : PTR_W'(ctl_field);

  always_comb begin
    idx_view            = '0;
    idx_view[AUTO_BIT]  = auto_o;
    idx_view[SPLIT_BIT] = split_o;
    idx_view[PTR_W-1:0] = ptr_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o       <= '0;
      auto_o      <= 1'b0;
      split_o     <= 1'b0;
      max_o       <= '1;
      rvalid_o    <= 1'b0;
      rsel_data_o <= 1'b0;
      rvoid_o     <= 1'b0;
      rreg_o      <= '0;
    end else begin
      rvalid_o <= rd_any;
      if (rd_any) begin
        rsel_data_o <= (cfg_sel == SEL_DATA);
        rvoid_o     <= !in_tab;
        case (cfg_sel)
          SEL_INDEX: rreg_o <= idx_view;
          SEL_MAX_R: rreg_o <= 32'(max_o[0]);
          SEL_MAX_G: rreg_o <= 32'(max_o[1]);
          SEL_MAX_B: rreg_o <= 32'(max_o[2]);
          default:   rreg_o <= '0;
        endcase
      end
      if (wr_idx) begin
        auto_o  <= ctl_auto;
        split_o <= ctl_split;
        if (!ctl_auto) ptr_o <= idx_load;
      end
      if ((wr_dat || rd_dat) && auto_o && in_tab) ptr_o <= ptr_o + 1'b1;
      if (cfg_wr && cfg_sel == SEL_MAX_R) max_o[0] <= ctl_field[MAX_W-1:0];
      if (cfg_wr && cfg_sel == SEL_MAX_G) max_o[1] <= ctl_field[MAX_W-1:0];
      if (cfg_wr && cfg_sel == SEL_MAX_B) max_o[2] <= ctl_field[MAX_W-1:0];
    end
  end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int DEG_SIZE = 256,
  parameter int COMP_W   = 10,
  parameter int MAX_W    = 16,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int PTR_W   = ADDR_W + 1,
  localparam int PX_W    = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             cfg_rvalid,
  output logic [31:0]      cfg_rdata,
  input  logic             px_valid,
  input  logic [PX_W-1:0]  px_r,
  input  logic [PX_W-1:0]  px_g,
  input  logic [PX_W-1:0]  px_b,
  output logic             px_out_valid,
  output logic [MAX_W-1:0] px_out_r,
  output logic [MAX_W-1:0] px_out_g,
  output logic [MAX_W-1:0] px_out_b
);
  localparam int SPLIT_RANGE = DEPTH - DEG_SIZE;
  localparam int EXT_W       = MAX_W - COMP_W;

  logic                         mem_we, mem_re;
  logic [ADDR_W-1:0]            mem_addr;
  logic [PTR_W-1:0]             ptr_q;
  logic                         auto_q, split_q;
  logic [NUM_CH-1:0][MAX_W-1:0] max_q;
  logic                         rsel_data, rvoid;
  logic [31:0]                  rreg;
  logic [PX_W-1:0]              px_in   [NUM_CH];
  logic [COMP_W-1:0]            host_q  [NUM_CH];
  logic [COMP_W-1:0]            pix_q   [NUM_CH];
  logic [NUM_CH-1:0]            over_q;
  logic [MAX_W-1:0]             out_q   [NUM_CH];
  logic                         vld1_q;
  logic [PX_W-1:0]              range_lim;
  logic [ADDR_W-1:0]            base_addr;

  gamma_lut_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_W(MAX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .ctl_auto(cfg_wdata[AUTO_BIT]), .ctl_split(cfg_wdata[SPLIT_BIT]),
    .ctl_field(cfg_wdata[IDX_FIELD_W-1:0]),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .ptr_o(ptr_q), .auto_o(auto_q), .split_o(split_q), .max_o(max_q),
    .rvalid_o(cfg_rvalid), .rsel_data_o(rsel_data), .rvoid_o(rvoid), .rreg_o(rreg)
  );

  assign px_in[0]  = px_r;
  assign px_in[1]  = px_g;
  assign px_in[2]  = px_b;
  assign range_lim = split_q ? PX_W'(SPLIT_RANGE) : PX_W'(DEPTH);
  assign base_addr = split_q ? ADDR_W'(DEG_SIZE) : '0;

  // one table copy per channel: shared host port, private pixel port
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int HI = (NUM_CH - c) * COMP_W - 1;
    logic [ADDR_W-1:0] px_addr;
    assign px_addr = base_addr + px_in[c][ADDR_W-1:0];

    gamma_lut_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(COMP_W)) u_bank (
      .clk(clk), .a_we(mem_we), .a_re(mem_re), .a_addr(mem_addr),
      .a_wdata(cfg_wdata[HI -: COMP_W]), .a_q(host_q[c]),
      .b_re(px_valid), .b_addr(px_addr), .b_q(pix_q[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        over_q[c] <= 1'b0;
        out_q[c]  <= '0;
      end else begin
        if (px_valid) over_q[c] <= (px_in[c] >= range_lim);
        if (vld1_q)
          out_q[c] <= over_q[c] ? max_q[c] : {pix_q[c], pix_q[c][COMP_W-1 -: EXT_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1_q       <= 1'b0;
      px_out_valid <= 1'b0;
    end else begin
      vld1_q       <= px_valid;
      px_out_valid <= vld1_q;
    end
  end

  assign px_out_r  = out_q[0];
  assign px_out_g  = out_q[1];
  assign px_out_b  = out_q[2];
  assign cfg_rdata = !rsel_data ? rreg
                   : rvoid     ? '0
                   : 32'({host_q[0], host_q[1], host_q[2]});
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int DEPTH = 512,
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [2:0]       cfg_sel,
  input logic [31:0]      cfg_wdata,
  input logic             cfg_rvalid,
  input logic             px_valid,
  input logic             px_out_valid,
  input logic [PTR_W-1:0] ptr_q,
  input logic             auto_q
);
  // R6
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_W'(DEPTH));

  // R5
  auto_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 3'd0 && cfg_wdata[31]) |=> (ptr_q == $past(ptr_q)));

  // R3
  data_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 3'd1 && auto_q && ptr_q < PTR_W'(DEPTH))
      |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel == 3'd1 && !auto_q) |=> $stable(ptr_q));

  // R7
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && !cfg_wr) |=> cfg_rvalid);

  // R7
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_rd && !cfg_wr) |=> !cfg_rvalid);

  // R8
  px_latency_chk: assert property (@(posedge clk) disable iff (rst)
    px_valid |=> ##1 px_out_valid);
endmodule

bind gamma_lut gamma_lut_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_gamma_lut_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .px_valid(px_valid),
  .px_out_valid(px_out_valid), .ptr_q(ptr_q), .auto_q(auto_q)
);

// File: tb/test_gamma_lut.sv
module test_gamma_lut;
  localparam int PX_W  = 10;
  localparam int MAX_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]       cfg_sel = '0;
  logic [31:0]      cfg_wdata = '0;
  logic             cfg_rvalid;
  logic [31:0]      cfg_rdata;
  logic             px_valid = 1'b0;
  logic [PX_W-1:0]  px_r = '0, px_g = '0, px_b = '0;
  logic             px_out_valid;
  logic [MAX_W-1:0] px_out_r, px_out_g, px_out_b;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  gamma_lut i_gamma_lut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .px_valid(px_valid), .px_r(px_r), .px_g(px_g), .px_b(px_b),
    .px_out_valid(px_out_valid), .px_out_r(px_out_r), .px_out_g(px_out_g),
    .px_out_b(px_out_b)
  );

  typedef struct packed {
    logic        rd;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  // rd=0: write data to sel; rd=1: read sel and expect data
  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'h0000_0000, 4'd1},  // R1 pointer and flags clear
    '{1'b1, 3'd2, 32'h0000_FFFF, 4'd1},  // R1 red ceiling
    '{1'b1, 3'd4, 32'h0000_FFFF, 4'd1},  // R1 blue ceiling
    '{1'b0, 3'd0, 32'h0000_0005, 4'd2},
    '{1'b1, 3'd0, 32'h0000_0005, 4'd2},  // R2 plain index load
    '{1'b0, 3'd0, 32'h8000_0007, 4'd5},
    '{1'b1, 3'd0, 32'h8000_0005, 4'd5},  // R5 index bits ignored
    '{1'b0, 3'd1, 32'h3FF5_5401, 4'd3},
    '{1'b0, 3'd1, 32'h1234_5678, 4'd3},
    '{1'b1, 3'd0, 32'h8000_0007, 4'd3},  // R3 two steps
    '{1'b0, 3'd0, 32'h0000_0005, 4'd2},
    '{1'b1, 3'd0, 32'h0000_0005, 4'd2},  // R2 auto-step cleared
    '{1'b1, 3'd1, 32'h3FF5_5401, 4'd7},  // R7 read entry 5
    '{1'b1, 3'd1, 32'h3FF5_5401, 4'd7},  // R7 no step without auto
    '{1'b0, 3'd0, 32'h8000_0000, 4'd5},
    '{1'b1, 3'd1, 32'h3FF5_5401, 4'd7},  // R7
    '{1'b1, 3'd1, 32'h1234_5678, 4'd7},  // R7 read stepped
    '{1'b1, 3'd0, 32'h8000_0007, 4'd7},  // R7 pointer after reads
    '{1'b0, 3'd0, 32'h0000_0009, 4'd4},
    '{1'b0, 3'd1, 32'h0FFF_FFFF, 4'd4},
    '{1'b0, 3'd1, 32'hC000_03FF, 4'd4},
    '{1'b1, 3'd1, 32'h0000_03FF, 4'd4},  // R4 overwrite, top bits dropped
    '{1'b1, 3'd0, 32'h0000_0009, 4'd4},  // R4 pointer held
    '{1'b0, 3'd3, 32'hABCD_1234, 4'd11},
    '{1'b1, 3'd3, 32'h0000_1234, 4'd11}, // R11 low 16 bits kept
    '{1'b1, 3'd2, 32'h0000_FFFF, 4'd11}, // R11 red untouched
    '{1'b0, 3'd0, 32'h0000_FFFF, 4'd2},
    '{1'b1, 3'd0, 32'h0000_0200, 4'd2},  // R2 clamp to DEPTH
    '{1'b0, 3'd0, 32'h4000_0003, 4'd9},
    '{1'b1, 3'd0, 32'h4000_0003, 4'd9},  // R9 split flag visible
    '{1'b0, 3'd0, 32'h0000_0000, 4'd2},
    '{1'b1, 3'd0, 32'h0000_0000, 4'd2}   // R2 split cleared
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] sel, input logic [31:0] exp, input int req);
    cfg_rd = 1'b1; cfg_sel = sel;
    @(posedge clk);
    @(negedge clk);
    cfg_rd = 1'b0;
    check(cfg_rvalid === 1'b1, req, "rvalid", 32'(cfg_rvalid), 32'd1);
    check(cfg_rdata === exp, req, "rdata", cfg_rdata, exp);
  endtask

  task automatic px_chk(input logic [PX_W-1:0] r, g, b,
                        input logic [MAX_W-1:0] er, eg, eb, input int req);
    px_valid = 1'b1; px_r = r; px_g = g; px_b = b;
    @(negedge clk);
    px_valid = 1'b0;
    @(negedge clk);
    check(px_out_valid === 1'b1, 8, "px_out_valid", 32'(px_out_valid), 32'd1);
    check(px_out_r === er, req, "px_out_r", 32'(px_out_r), 32'(er));
    check(px_out_g === eg, req, "px_out_g", 32'(px_out_g), 32'(eg));
    check(px_out_b === eb, req, "px_out_b", 32'(px_out_b), 32'(eb));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 outputs quiet after reset
    check(cfg_rvalid === 1'b0, 1, "rvalid after reset", 32'(cfg_rvalid), 32'd0);
    check(px_out_valid === 1'b0, 1, "px_out_valid after reset", 32'(px_out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) reg_rd(VECS[i].sel, VECS[i].data, int'(VECS[i].req));
      else            reg_wr(VECS[i].sel, VECS[i].data);
    end

    // R6 saturation at the end of the table
    reg_wr(3'd0, 32'h0000_01FF);
    reg_wr(3'd0, 32'h8000_0000);
    reg_wr(3'd1, 32'h0030_0C03);
    reg_rd(3'd0, 32'h8000_0200, 6);
    reg_wr(3'd1, 32'h3FFF_FFFF);
    reg_rd(3'd1, 32'h0000_0000, 6);
    reg_rd(3'd0, 32'h8000_0200, 6);
    reg_wr(3'd0, 32'h0000_01FF);
    reg_rd(3'd1, 32'h0030_0C03, 6);

    // R8 per-channel lookup, unsplit
    px_chk(10'd5, 10'd5, 10'd6, 16'hFFFF, 16'h5555, 16'h9E27, 8);
    // R10 ceiling at and above range, last in-range entry
    px_chk(10'd512, 10'd512, 10'd511, 16'hFFFF, 16'h1234, 16'h00C0, 10);
    px_chk(10'd1023, 10'd6, 10'd1023, 16'hFFFF, 16'h4551, 16'hFFFF, 10);

    // R9 split offset
    reg_wr(3'd0, 32'h0000_0103);
    reg_wr(3'd1, 32'h0010_0802);
    reg_wr(3'd0, 32'h4000_0000);
    px_chk(10'd3, 10'd256, 10'd3, 16'h0040, 16'h1234, 16'h0080, 9);
    px_chk(10'd255, 10'd3, 10'd255, 16'h00C0, 16'h0080, 16'h00C0, 9);
    reg_wr(3'd0, 32'h0000_0000);
    px_chk(10'd259, 10'd259, 10'd259, 16'h0040, 16'h0080, 16'h0080, 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule